// File: doc/BRIEF.md
# SD Card Write Data-Path Sequencer

This block moves a host byte stream onto the data lines of an SD/MMC card during a write transfer. Software-side logic supplies a total byte count, a block length and a bus width (1, 4 or 8 lines), then pulses a start input. The block pulls bytes over a valid/ready handshake and cuts the stream into blocks. Each block goes out as a low start bit, the data, one CRC-16 per active line and a high end bit.

After each block the line drivers are released. The block listens on line 0 for the card's three-bit CRC status token, then waits out the card's busy period. A rejected block is reported and the transfer carries on. A token whose start bit never arrives stops the transfer at once. The block can also request an automatic STOP command from the command path, timed to the last block.

The state machine walks through these states: `S_IDLE`, `S_SOF` (start bit), `S_DATA`, `S_CRC`, `S_EOF` (end bit), `S_WAIT_TOK`, `S_TOKEN`, `S_TOK_END` and `S_BUSY`. The transitions are:

- `S_IDLE` goes to `S_SOF` on a start pulse.
- `S_SOF` always goes to `S_DATA`.
- `S_DATA` goes to `S_CRC` when the block's last beat is sent.
- `S_CRC` goes to `S_EOF` after 16 beats.
- `S_EOF` always goes to `S_WAIT_TOK`.
- `S_WAIT_TOK` goes to `S_TOKEN` when line 0 is low. It goes to `S_IDLE` (abort) if line 0 is still high in its second cycle.
- `S_TOKEN` goes to `S_TOK_END` after three bits.
- `S_TOK_END` always goes to `S_BUSY`.
- `S_BUSY` waits for line 0 to be high. It then goes to `S_SOF` while bytes remain, and to `S_IDLE` when none remain.

Top module: `sdw_write_path`

## Requirements
- R1: When the byte count equals the block length, exactly one block is sent, and exactly that many bytes are taken from the source.
- R2: Otherwise, blocks of block-length bytes are sent back to back, taking source bytes in order, until the remaining count is zero.
- R3: A block drives a 0 on every active line for one cycle and then the data. Width code 0 sends 1 line, MSB first on line 0. Code 1 sends 4 lines, high nibble first, with bit 3 of the nibble on line 3. Code 2 sends 8 lines, one byte per cycle, with bit i on line i. After the CRC, the block drives a 1 on every active line for one cycle.
- R4: After the data, each active line carries its own 16-bit CRC for 16 cycles, MSB first. The CRC is cleared at each block start and uses the polynomial x^16+x^12+x^5+1.
- R5: The status token on line 0 is a 0 start bit that arrives in the first or second cycle after the end bit. Three bits and an end bit follow. The bits 010 mean accepted and raise no error.
- R6: Any other token raises a one-cycle CRC error pulse, and the following blocks are still sent.
- R7: If line 0 is still high two cycles after the end bit, a one-cycle start-bit error pulse is raised. No further block is sent and no done pulse follows.
- R8: A one-cycle done pulse follows the first high on line 0 after the last block's token, and only when no bytes remain.
- R9: With auto-stop set and a block length of at least 4, 16 or 32 bytes (for codes 0, 1, 2), a one-cycle stop request appears in the cycle after the last block's start bit. With auto-stop clear, no stop request appears.
- R10: With auto-stop set and a block length below that limit, the stop request appears in the cycle after the last block's end bit.
- R11: Lines outside the selected width are never enabled and read as 1, and no line is enabled while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Start pulse, taken only in idle |
| cfg_byte_count | input | CNT_W | Total bytes of the transfer |
| cfg_block_bytes | input | BLK_W | Bytes per block |
| cfg_bus_width | input | 2 | 0: 1 line, 1: 4 lines, 2: 8 lines |
| cfg_auto_stop | input | 1 | Request a STOP command for the last block |
| src_data | input | 8 | Source byte |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Byte taken this cycle when valid |
| dat_out | output | 8 | Data line drive values |
| dat_oe | output | 8 | Per-line output enable |
| dat_in0 | input | 1 | Sampled level of data line 0 |
| busy | output | 1 | Transfer in progress |
| done_pulse | output | 1 | Transfer complete |
| crc_err_pulse | output | 1 | Card rejected a block |
| sbe_pulse | output | 1 | Status start bit missing, transfer aborted |
| stop_req | output | 1 | Request for an automatic STOP command |

## Verification
The assertions assume a few things about the inputs:
- The source keeps `src_valid` high for the whole data phase, so the bus never stalls mid-block.
- The byte count is a nonzero multiple of the block length.
- The width code is 0, 1 or 2.

The stimulus picks every transfer from these legal sets, always offers a byte, and ties line 0 high except where the card model drives it. The card model plays token timing, token value and busy length.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int LANES = 8;
    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [2:0] TOKEN_OK = 3'b010;

    typedef enum logic [3:0] {
        S_IDLE, S_SOF, S_DATA, S_CRC, S_EOF,
        S_WAIT_TOK, S_TOKEN, S_TOK_END, S_BUSY
    } wr_state_e;

    typedef enum logic [1:0] {
        BUS_X1 = 2'd0,
        BUS_X4 = 2'd1,
        BUS_X8 = 2'd2
    } bus_width_e;

    function automatic logic [LANES-1:0] lane_mask(bus_width_e w);
        case (w)
            BUS_X4:  return 8'h0F;
            BUS_X8:  return 8'hFF;
            default: return 8'h01;
        endcase
    endfunction

    function automatic logic [2:0] last_beat_idx(bus_width_e w);
        case (w)
            BUS_X4:  return 3'd1;
            BUS_X8:  return 3'd0;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [5:0] short_limit(bus_width_e w);
        case (w)
            BUS_X4:  return 6'd16;
            BUS_X8:  return 6'd32;
            default: return 6'd4;
        endcase
    endfunction

endpackage

// File: rtl/sdw_lane_crc.sv
module sdw_lane_crc #(
    parameter int CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic feed,
    input  logic bit_in,
    input  logic shift,
    output logic msb
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clear) begin
            crc_q <= '0;
        end else if (feed) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{crc_q[CRC_W-1] ^ bit_in}} & POLY);
        end else if (shift) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = crc_q[CRC_W-1];
endmodule

// File: rtl/sdw_lane_map.sv
module sdw_lane_map
    import sdw_pkg::*;
(
    input  logic [7:0]       byte_in,
    input  logic [2:0]       beat,
    input  bus_width_e       width,
    output logic [LANES-1:0] lanes
);
    always_comb begin
        lanes = '1;
        case (width)
            BUS_X4:  lanes[3:0] = (beat == 3'd0) ? byte_in[7:4] : byte_in[3:0];
            BUS_X8:  lanes = byte_in;
            default: lanes[0] = byte_in[3'd7 - beat];
        endcase
    end
endmodule

// File: rtl/sdw_write_path.sv
module sdw_write_path
    import sdw_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic [CNT_W-1:0] cfg_byte_count,
    input  logic [BLK_W-1:0] cfg_block_bytes,
    input  logic [1:0]       cfg_bus_width,
    input  logic             cfg_auto_stop,
    input  logic [7:0]       src_data,
    input  logic             src_valid,
    output logic             src_ready,
    output logic [7:0]       dat_out,
    output logic [7:0]       dat_oe,
    input  logic             dat_in0,
    output logic             busy,
    output logic             done_pulse,
    output logic             crc_err_pulse,
    output logic             sbe_pulse,
    output logic             stop_req
);
    localparam int SUB_W = 4;
    localparam logic [SUB_W-1:0] CRC_LAST = SUB_W'(CRC_W - 1);

    wr_state_e        state_q, state_d;
    bus_width_e       w_q;
    logic [BLK_W-1:0] blk_q, blk_left_q;
    logic [CNT_W-1:0] rem_q;
    logic             auto_q;
    logic [2:0]       beat_q;
    logic [SUB_W-1:0] sub_q;
    logic [7:0]       byte_q;
    logic [2:0]       tok_q;

    logic [LANES-1:0] mask, lane_bits, crc_msb;
    logic [7:0]       cur_byte;
    logic beat_go, consume, byte_end, blk_end, rem_zero, short_blk, last_blk;

    assign mask      = lane_mask(w_q);
    assign beat_go   = (state_q == S_DATA) && ((beat_q != 3'd0) || src_valid);
    assign consume   = (state_q == S_DATA) && (beat_q == 3'd0) && src_valid;
    assign cur_byte  = (beat_q == 3'd0) ? src_data : byte_q;
    assign byte_end  = beat_go && (beat_q == last_beat_idx(w_q));
    assign blk_end   = byte_end && (consume ? (blk_left_q == BLK_W'(1)) : (blk_left_q == '0));
    assign rem_zero  = (rem_q == '0);
    assign short_blk = blk_q < BLK_W'(short_limit(w_q));
    assign last_blk  = (rem_q == CNT_W'(blk_q));

    sdw_lane_map u_map (
        .byte_in (cur_byte),
        .beat    (beat_q),
        .width   (w_q),
        .lanes   (lane_bits)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sdw_lane_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (state_q == S_SOF),
            .feed   (beat_go),
            .bit_in (lane_bits[i]),
            .shift  (state_q == S_CRC),
            .msb    (crc_msb[i])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (xfer_start) state_d = S_SOF;
            S_SOF:      state_d = S_DATA;
            S_DATA:     if (blk_end) state_d = S_CRC;
            S_CRC:      if (sub_q == CRC_LAST) state_d = S_EOF;
            S_EOF:      state_d = S_WAIT_TOK;
            S_WAIT_TOK: begin
                if (!dat_in0)                 state_d = S_TOKEN;
                else if (sub_q == SUB_W'(1))  state_d = S_IDLE;
            end
            S_TOKEN:    if (sub_q == SUB_W'(2)) state_d = S_TOK_END;
            S_TOK_END:  state_d = S_BUSY;
            S_BUSY:     if (dat_in0) state_d = rem_zero ? S_IDLE : S_SOF;
            default:    state_d = S_IDLE;
        endcase
    end

    // datapath and status pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= BUS_X1;  blk_q <= '0;  blk_left_q <= '0;  rem_q <= '0;
            auto_q <= 1'b0; beat_q <= '0; sub_q <= '0;       byte_q <= '0;
            tok_q <= '0;
            done_pulse <= 1'b0; crc_err_pulse <= 1'b0; sbe_pulse <= 1'b0; stop_req <= 1'b0;
        end else begin
            sub_q <= (state_d != state_q) ? '0 : sub_q + SUB_W'(1);
            if (state_q == S_IDLE && xfer_start) begin
                w_q    <= bus_width_e'(cfg_bus_width);
                blk_q  <= cfg_block_bytes;
                rem_q  <= cfg_byte_count;
                auto_q <= cfg_auto_stop;
            end
            if (state_q == S_SOF) begin
                blk_left_q <= blk_q;
                beat_q     <= '0;
            end
            if (consume) begin
                byte_q     <= src_data;
                rem_q      <= rem_q - CNT_W'(1);
                blk_left_q <= blk_left_q - BLK_W'(1);
            end
            if (beat_go) beat_q <= byte_end ? 3'd0 : beat_q + 3'd1;
            if (state_q == S_TOKEN) tok_q <= {tok_q[1:0], dat_in0};
            done_pulse    <= (state_q == S_BUSY) && dat_in0 && rem_zero;
            crc_err_pulse <= (state_q == S_TOK_END) && (tok_q != TOKEN_OK);
            sbe_pulse     <= (state_q == S_WAIT_TOK) && dat_in0 && (sub_q == SUB_W'(1));
            stop_req      <= auto_q && (short_blk ? (state_q == S_EOF && rem_zero)
                                                  : (state_q == S_SOF && last_blk));
        end
    end

    // bus outputs
    always_comb begin
        dat_oe    = '0;
        dat_out   = '1;
        src_ready = 1'b0;
        unique case (state_q)
            S_SOF: begin
                dat_oe  = mask;
                dat_out = ~mask;
            end
            S_DATA: begin
                dat_oe    = mask;
                dat_out   = lane_bits | ~mask;
                src_ready = (beat_q == 3'd0);
            end
            S_CRC: begin
                dat_oe  = mask;
                dat_out = crc_msb | ~mask;
            end
            S_EOF:  dat_oe = mask;
            default: ;
        endcase
    end

    assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/sdw_write_path_chk.sv
module sdw_write_path_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] dat_out,
    input logic [7:0] dat_oe,
    input logic       src_ready,
    input logic       busy,
    input logic       done_pulse,
    input logic       crc_err_pulse,
    input logic       sbe_pulse
);
    assert_oe_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe == 8'h00 || dat_oe == 8'h01 || dat_oe == 8'h0F || dat_oe == 8'hFF);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dat_oe == 8'h00);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe[0]) |-> dat_out[0] == 1'b0);

    assert_end_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_oe[0]) |-> $past(dat_out[0]) == 1'b1);

    assert_ready_on_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> dat_oe[0]);

    assert_crc_err_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_pulse |-> busy);

    assert_sbe_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sbe_pulse |-> !busy && !done_pulse);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy);
endmodule

bind sdw_write_path sdw_write_path_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dat_out       (dat_out),
    .dat_oe        (dat_oe),
    .src_ready     (src_ready),
    .busy          (busy),
    .done_pulse    (done_pulse),
    .crc_err_pulse (crc_err_pulse),
    .sbe_pulse     (sbe_pulse)
);

// File: tb/tb_sdw_write_path.sv
module tb_sdw_write_path;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int BLK_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xfer_start = 1'b0;
    logic [CNT_W-1:0] cfg_byte_count = '0;
    logic [BLK_W-1:0] cfg_block_bytes = '0;
    logic [1:0]       cfg_bus_width = '0;
    logic             cfg_auto_stop = 1'b0;
    logic [7:0]       src_data;
    logic             src_valid = 1'b1;
    logic             src_ready;
    logic [7:0]       dat_out, dat_oe;
    logic             dat_in0 = 1'b1;
    logic             busy, done_pulse, crc_err_pulse, sbe_pulse, stop_req;

    sdw_write_path #(.CNT_W(CNT_W), .BLK_W(BLK_W)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
        .cfg_byte_count(cfg_byte_count), .cfg_block_bytes(cfg_block_bytes),
        .cfg_bus_width(cfg_bus_width), .cfg_auto_stop(cfg_auto_stop),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .dat_out(dat_out), .dat_oe(dat_oe), .dat_in0(dat_in0),
        .busy(busy), .done_pulse(done_pulse), .crc_err_pulse(crc_err_pulse),
        .sbe_pulse(sbe_pulse), .stop_req(stop_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [7:0] mem [1024];
    int unsigned rd_idx = 0;
    int unsigned cyc = 0;
    int n_done = 0, n_crc = 0, n_sbe = 0, n_stop = 0;
    int unsigned stop_cyc = 0;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    assign src_data = mem[rd_idx % 1024];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) rd_idx <= 0;
        else if (src_ready && src_valid) rd_idx <= rd_idx + 1;
    end

    always @(negedge clk) begin
        if (done_pulse)    n_done++;
        if (crc_err_pulse) n_crc++;
        if (sbe_pulse)     n_sbe++;
        if (stop_req) begin n_stop++; stop_cyc = cyc; end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int w);
        return (w == 2) ? 8'hFF : (w == 1) ? 8'h0F : 8'h01;
    endfunction

    function automatic int beats_of(input int w);
        return (w == 2) ? 1 : (w == 1) ? 2 : 8;
    endfunction

    function automatic logic [7:0] exp_lanes(input logic [7:0] b, input int w, input int beat);
        logic [7:0] r = 8'hFF;
        if (w == 2)      r = b;
        else if (w == 1) r[3:0] = (beat == 0) ? b[7:4] : b[3:0];
        else             r[0] = b[7 - beat];
        return r;
    endfunction

    // x^16 + x^12 + x^5 + 1, one input bit
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic d);
        logic fb = c[15] ^ d;
        logic [15:0] n = c << 1;
        if (fb) begin n[0] = ~n[0]; n[5] = ~n[5]; n[12] = ~n[12]; end
        return n;
    endfunction

    // Observes one block from its start bit and answers as the card.
    task automatic card_block(input int w, input int blk, input int unsigned base,
                              input bit tok_bad, input int d, input int k,
                              output int unsigned sof_c, output int unsigned eof_c);
        logic [7:0]  m = mask_of(w);
        logic [15:0] cr [8];
        logic [7:0]  e, eb;
        logic [2:0]  tokv = tok_bad ? 3'b101 : 3'b010;
        int waited = 0, mism = 0, cm = 0;
        for (int l = 0; l < 8; l++) cr[l] = '0;
        while (!dat_oe[0] && waited < 64) begin @(negedge clk); waited++; end
        check(dat_oe == m && dat_out == ~m, "R3", "start bit lines", dat_out, ~m);
        sof_c = cyc;
        for (int j = 0; j < blk; j++) begin
            eb = mem[(base + j) % 1024];
            for (int bt = 0; bt < beats_of(w); bt++) begin
                @(negedge clk);
                e = exp_lanes(eb, w, bt);
                if (dat_out !== e || dat_oe !== m) mism++;
                for (int l = 0; l < 8; l++) if (m[l]) cr[l] = crc_step(cr[l], e[l]);
            end
        end
        check(mism == 0, "R3", "data beats mismatched", mism, 0);
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            for (int l = 0; l < 8; l++)
                if (dat_out[l] !== (m[l] ? cr[l][15 - t] : 1'b1)) cm++;
        end
        check(cm == 0, "R4", "crc beats mismatched", cm, 0);
        @(negedge clk);
        check(dat_out == 8'hFF && dat_oe == m, "R3", "end bit lines", dat_out, 8'hFF);
        eof_c = cyc;
        for (int i = 0; i < d && i < 2; i++) begin @(negedge clk); dat_in0 = 1'b1; end
        if (d >= 2) return;
        @(negedge clk); dat_in0 = 1'b0;
        for (int i = 2; i >= 0; i--) begin @(negedge clk); dat_in0 = tokv[i]; end
        @(negedge clk); dat_in0 = 1'b1;
        for (int i = 0; i < k; i++) begin @(negedge clk); dat_in0 = 1'b0; end
        @(negedge clk); dat_in0 = 1'b1;
    endtask

    task automatic run_xfer(input int w, input int blk, input int nblk, input bit auto_s,
                            input int err_blk, input int sbe_blk, input int k);
        int d0 = n_done, c0 = n_crc, s0 = n_sbe, p0 = n_stop;
        int unsigned base = rd_idx, sof_c = 0, eof_c = 0;
        int sent = 0, quiet = 0;
        bit shrt = (blk < ((w == 2) ? 32 : (w == 1) ? 16 : 4));
        cfg_bus_width = w[1:0]; cfg_block_bytes = BLK_W'(blk);
        cfg_byte_count = CNT_W'(blk * nblk); cfg_auto_stop = auto_s;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        for (int b = 0; b < nblk; b++) begin
            card_block(w, blk, base + b * blk, b == err_blk,
                       (b == sbe_blk) ? 2 : int'($urandom % 2), k, sof_c, eof_c);
            sent++;
            if (b == sbe_blk) break;
        end
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (dat_oe != 0) quiet++; end
        check(rd_idx - base == blk * sent, (nblk == 1) ? "R1" : "R2", "bytes taken", rd_idx - base, blk * sent);
        if (sbe_blk >= 0) begin
            check(n_sbe - s0 == 1, "R7", "start-bit error pulses", n_sbe - s0, 1);
            check(n_done - d0 == 0 && quiet == 0 && !busy, "R7", "activity after abort", n_done - d0 + quiet, 0);
        end else begin
            check(n_done - d0 == 1, "R8", "done pulses", n_done - d0, 1);
            check(n_sbe - s0 == 0, "R5", "spurious start-bit error", n_sbe - s0, 0);
        end
        if (err_blk >= 0 && err_blk < sent)
            check(n_crc - c0 == 1, "R6", "crc error pulses", n_crc - c0, 1);
        else
            check(n_crc - c0 == 0, "R5", "crc error on accepted token", n_crc - c0, 0);
        if (auto_s && sbe_blk < 0) begin
            check(n_stop - p0 == 1, shrt ? "R10" : "R9", "stop requests", n_stop - p0, 1);
            if (shrt) check(stop_cyc == eof_c + 1, "R10", "stop cycle after end bit", stop_cyc, eof_c + 1);
            else      check(stop_cyc == sof_c + 1, "R9", "stop cycle after last start bit", stop_cyc, sof_c + 1);
        end else if (!auto_s) begin
            check(n_stop - p0 == 0, "R9", "stop without auto-stop", n_stop - p0, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dat_oe == 0 && !src_ready && !busy, "R11", "reset state", dat_oe, 0);
        check(!done_pulse && !crc_err_pulse && !sbe_pulse && !stop_req, "R8", "reset pulses", done_pulse, 0);
        // directed corners
        run_xfer(2, 10, 1, 1'b1, -1, -1, 2);  // single block, 8 lines, short
        run_xfer(2, 3, 3, 1'b1, -1, -1, 0);   // short blocks, 8 lines
        run_xfer(0, 4, 2, 1'b1, -1, -1, 1);   // limit exactly, 1 line
        run_xfer(0, 3, 2, 1'b1, -1, -1, 1);   // just below limit
        run_xfer(1, 16, 2, 1'b1, -1, -1, 3);  // limit exactly, 4 lines
        run_xfer(1, 15, 1, 1'b1, -1, -1, 0);
        run_xfer(2, 32, 2, 1'b1, -1, -1, 1);
        run_xfer(0, 5, 3, 1'b0, 1, -1, 2);    // rejected middle block
        run_xfer(1, 6, 3, 1'b0, -1, 1, 0);    // missing start bit
        run_xfer(2, 2, 4, 1'b0, -1, 0, 0);    // missing on first block
        for (int t = 0; t < 30; t++) begin
            int w = int'($urandom % 3);
            int blk = 1 + int'($urandom % 40);
            int nb = 1 + int'($urandom % 4);
            int eb = ($urandom % 3 == 0) ? int'($urandom % nb) : -1;
            run_xfer(w, blk, nb, 1'($urandom % 2), eb, -1, int'($urandom % 4));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule